// File: doc/BRIEF.md
# Hinted Branch Predictor with Predication Cost

This block predicts conditional branches for a fetch front end. Each branch displacement carries a hint in its least significant bit. The hint reverses the usual static rule, under which a forward branch is predicted not taken and a backward branch taken. Alongside the static rule sits a small direct-mapped branch cache. Each cache line keeps the following:

- the last outcome of the branch;
- a saturating taken-rate counter;
- the clipped cycle cost measured for the predicated shadow region;
- the last taken target.

From these the block also decides whether the skipped region of a forward branch should be predicated rather than branched over. A cheap region is always predicated. A costlier region is predicated only while the branch is taken less often than a threshold that tightens with cost. A region whose cost was clipped is never predicated.

A lookup is purely combinational from the presented PC and displacement. The execution stage reports each resolved branch on a one-cycle strobe. The strobe carries the outcome, the target and, when the predicated region was executed and measured, its cycle count. A resolve allocates a line on a miss or updates the line on a hit.

Top module: `hint_branch_predictor`

## Requirements
- R1: On a cache miss, the predicted direction is static. The displacement is two's complement, and its top bit set means backward. Bit 0 is the hint: with bit 0 = 0, forward is predicted not taken and backward taken; with bit 0 = 1, both are reversed.
- R2: On a miss, predicate-enable is 1 exactly when the branch is forward and predicted not taken. The target-valid output is 0 on a miss.
- R3: The line index is PC bits [4:1] and the tag is PC bits [31:5]. A resolve on a miss allocates the line and replaces whatever tag was there. A later lookup of that PC hits and predicts the last resolved outcome.
- R4: The taken-rate counter is 4 bits. Allocation sets it to 8 when taken and 7 when not taken. Each hit resolve adds 1 when taken and subtracts 1 when not taken, saturating at 15 and 0.
- R5: When a resolve is marked measured, its cycle count is clipped to 7 and stored as the cost. An unmeasured allocation stores cost 0, and an unmeasured hit keeps the stored cost.
- R6: On a hit, a backward branch is never predicated. A forward branch is predicated as follows: cost 0 or 1 always; cost 2 only when the counter is below 14; cost 3 only when it is below 11; cost 4 or more never.
- R7: A taken resolve stores its target, and a not-taken resolve leaves the stored target alone. On a hit whose line holds a target, target-valid is 1 and the predicted target is the stored value. Otherwise target-valid is 0 and the target is the PC plus the sign-extended displacement with bit 0 cleared.
- R8: When a lookup and a resolve address the same line in one cycle, the lookup reflects the line as it was before that resolve. The update is visible from the next cycle.
- R9: After reset every line is invalid, so every lookup behaves as a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | 32 | PC of the branch being looked up |
| lk_disp | input | 16 | Displacement; bit 0 is the hint |
| res_valid | input | 1 | Resolve strobe, one cycle per branch |
| res_pc | input | 32 | PC of the resolved branch |
| res_taken | input | 1 | Resolved outcome |
| res_target | input | 32 | Resolved target address |
| res_measured | input | 1 | res_cycles holds a measured predication cost |
| res_cycles | input | 8 | Measured cycles of the predicated region |
| pred_taken | output | 1 | Predicted direction |
| pred_en | output | 1 | Predicate the shadow region instead of branching |
| tgt_valid | output | 1 | pred_target comes from the cache |
| pred_target | output | 32 | Predicted target address |

## Verification
A lookup and a resolve can fall on the same line in the same cycle. The bench provokes this by presenting the lookup PC and the resolve strobe for an unallocated PC together. It requires the combinational outputs in that cycle to show a miss, and the allocated target to appear one cycle later. Other scenarios are judged at the ports alone. These cover counter threshold crossings, saturation, cost clipping and line replacement, with expected values derived by hand from the requirements.

// File: rtl/hbp_pkg.sv
package hbp_pkg;

    // Predication policy: cheap regions always, dearer ones below a rate bound.
    function automatic logic cost_allows(input int unsigned cost,
                                         input int unsigned rate,
                                         input int unsigned thr_c2,
                                         input int unsigned thr_c3);
        logic ok;
        if (cost <= 1)       ok = 1'b1;
        else if (cost == 2)  ok = (rate < thr_c2);
        else if (cost == 3)  ok = (rate < thr_c3);
        else                 ok = 1'b0;
        return ok;
    endfunction

    // Ceiling of max * pct / 100.
    function automatic int unsigned pct_ceil(input int unsigned max_v,
                                             input int unsigned pct);
        return (max_v * pct + 99) / 100;
    endfunction

endpackage

// File: rtl/hbp_entry_next.sv
module hbp_entry_next #(
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 27,
    parameter int RATE_W = 4,
    parameter int COST_W = 3,
    parameter int CYC_W  = 8
) (
    input  logic              sel,
    input  logic              old_valid,
    input  logic [TAG_W-1:0]  old_tag,
    input  logic              old_hist,
    input  logic [RATE_W-1:0] old_rate,
    input  logic [COST_W-1:0] old_cost,
    input  logic              old_tv,
    input  logic [ADDR_W-1:0] old_tgt,
    input  logic [TAG_W-1:0]  res_tag,
    input  logic              res_taken,
    input  logic [ADDR_W-1:0] res_target,
    input  logic              res_measured,
    input  logic [CYC_W-1:0]  res_cycles,
    output logic              new_valid,
    output logic [TAG_W-1:0]  new_tag,
    output logic              new_hist,
    output logic [RATE_W-1:0] new_rate,
    output logic [COST_W-1:0] new_cost,
    output logic              new_tv,
    output logic [ADDR_W-1:0] new_tgt
);
    localparam int RATE_MAX = (1 << RATE_W) - 1;
    localparam int RATE_MID = RATE_MAX / 2;
    localparam int COST_MAX = (1 << COST_W) - 1;

    logic              hit;
    logic [COST_W-1:0] clipped_d;

    always_comb begin
        hit = old_valid && (old_tag == res_tag);
        if (32'(res_cycles) > COST_MAX) clipped_d = COST_W'(COST_MAX);
        else                            clipped_d = res_cycles[COST_W-1:0];

        new_valid = old_valid;
        new_tag   = old_tag;
        new_hist  = old_hist;
        new_rate  = old_rate;
        new_cost  = old_cost;
        new_tv    = old_tv;
        new_tgt   = old_tgt;
        if (sel) begin
            new_valid = 1'b1;
            new_tag   = res_tag;
            new_hist  = res_taken;
            if (!hit) begin
                new_rate = res_taken ? RATE_W'(RATE_MID + 1) : RATE_W'(RATE_MID);
                new_cost = res_measured ? clipped_d : '0;
                new_tv   = res_taken;
                new_tgt  = res_taken ? res_target : '0;
            end else begin
                if (res_taken && old_rate != RATE_W'(RATE_MAX))
                    new_rate = old_rate + 1'b1;
                else if (!res_taken && old_rate != '0)
                    new_rate = old_rate - 1'b1;
                if (res_measured) new_cost = clipped_d;
                if (res_taken) begin
                    new_tv  = 1'b1;
                    new_tgt = res_target;
                end
            end
        end
    end
endmodule

// File: rtl/hbp_decide.sv
module hbp_decide
    import hbp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 16,
    parameter int RATE_W = 4,
    parameter int COST_W = 3
) (
    input  logic [ADDR_W-1:0] lk_pc,
    input  logic [DISP_W-1:0] lk_disp,
    input  logic              hit,
    input  logic              ent_hist,
    input  logic [RATE_W-1:0] ent_rate,
    input  logic [COST_W-1:0] ent_cost,
    input  logic              ent_tv,
    input  logic [ADDR_W-1:0] ent_tgt,
    output logic              pred_taken,
    output logic              pred_en,
    output logic              tgt_valid,
    output logic [ADDR_W-1:0] pred_target
);
    localparam int unsigned RATE_MAX = (1 << RATE_W) - 1;
    localparam int unsigned THR_C2   = pct_ceil(RATE_MAX, 90);
    localparam int unsigned THR_C3   = pct_ceil(RATE_MAX, 70);

    logic              backward;
    logic              static_taken;
    logic [ADDR_W-1:0] disp_ext;

    always_comb begin
        backward     = lk_disp[DISP_W-1];
        static_taken = backward ^ lk_disp[0];
        disp_ext     = {{(ADDR_W-DISP_W){lk_disp[DISP_W-1]}}, lk_disp};
        disp_ext[0]  = 1'b0;

        if (hit) begin
            pred_taken = ent_hist;
            pred_en    = !backward &&
                         cost_allows(32'(ent_cost), 32'(ent_rate), THR_C2, THR_C3);
        end else begin
            pred_taken = static_taken;
            pred_en    = !backward && !static_taken;
        end
        tgt_valid   = hit && ent_tv;
        pred_target = tgt_valid ? ent_tgt : (lk_pc + disp_ext);
    end
endmodule

// File: rtl/hint_branch_predictor.sv
module hint_branch_predictor #(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 16,
    parameter int IDX_W  = 4,
    parameter int RATE_W = 4,
    parameter int COST_W = 3,
    parameter int CYC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_pc,
    input  logic [DISP_W-1:0] lk_disp,
    input  logic              res_valid,
    input  logic [ADDR_W-1:0] res_pc,
    input  logic              res_taken,
    input  logic [ADDR_W-1:0] res_target,
    input  logic              res_measured,
    input  logic [CYC_W-1:0]  res_cycles,
    output logic              pred_taken,
    output logic              pred_en,
    output logic              tgt_valid,
    output logic [ADDR_W-1:0] pred_target
);
    localparam int ENTRIES = 1 << IDX_W;
    localparam int TAG_W   = ADDR_W - IDX_W - 1;

    typedef struct packed {
        logic [ENTRIES-1:0]             valid;
        logic [ENTRIES-1:0][TAG_W-1:0]  tag;
        logic [ENTRIES-1:0]             hist;
        logic [ENTRIES-1:0][RATE_W-1:0] rate;
        logic [ENTRIES-1:0][COST_W-1:0] cost;
        logic [ENTRIES-1:0]             tv;
        logic [ENTRIES-1:0][ADDR_W-1:0] tgt;
    } table_t;

    table_t state_d, state_q;

    logic [IDX_W-1:0] lk_idx, res_idx;
    logic [TAG_W-1:0] lk_tag, res_tag;
    logic             lk_hit;

    always_comb begin
        lk_idx  = lk_pc[IDX_W:1];
        lk_tag  = lk_pc[ADDR_W-1:IDX_W+1];
        res_idx = res_pc[IDX_W:1];
        res_tag = res_pc[ADDR_W-1:IDX_W+1];
        lk_hit  = state_q.valid[lk_idx] && (state_q.tag[lk_idx] == lk_tag);
    end

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        hbp_entry_next #(
            .ADDR_W(ADDR_W), .TAG_W(TAG_W), .RATE_W(RATE_W),
            .COST_W(COST_W), .CYC_W(CYC_W)
        ) next_i (
            .sel         (res_valid && (res_idx == IDX_W'(e))),
            .old_valid   (state_q.valid[e]),
            .old_tag     (state_q.tag[e]),
            .old_hist    (state_q.hist[e]),
            .old_rate    (state_q.rate[e]),
            .old_cost    (state_q.cost[e]),
            .old_tv      (state_q.tv[e]),
            .old_tgt     (state_q.tgt[e]),
            .res_tag     (res_tag),
            .res_taken   (res_taken),
            .res_target  (res_target),
            .res_measured(res_measured),
            .res_cycles  (res_cycles),
            .new_valid   (state_d.valid[e]),
            .new_tag     (state_d.tag[e]),
            .new_hist    (state_d.hist[e]),
            .new_rate    (state_d.rate[e]),
            .new_cost    (state_d.cost[e]),
            .new_tv      (state_d.tv[e]),
            .new_tgt     (state_d.tgt[e])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    hbp_decide #(
        .ADDR_W(ADDR_W), .DISP_W(DISP_W), .RATE_W(RATE_W), .COST_W(COST_W)
    ) decide_i (
        .lk_pc      (lk_pc),
        .lk_disp    (lk_disp),
        .hit        (lk_hit),
        .ent_hist   (state_q.hist[lk_idx]),
        .ent_rate   (state_q.rate[lk_idx]),
        .ent_cost   (state_q.cost[lk_idx]),
        .ent_tv     (state_q.tv[lk_idx]),
        .ent_tgt    (state_q.tgt[lk_idx]),
        .pred_taken (pred_taken),
        .pred_en    (pred_en),
        .tgt_valid  (tgt_valid),
        .pred_target(pred_target)
    );

    // R3: a resolve leaves its line valid with its tag
    a_r3_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> (state_q.valid[$past(res_idx)] &&
                       state_q.tag[$past(res_idx)] == $past(res_tag)));

    // R8: without a resolve strobe the table holds still
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> $stable(state_q));

    // R6: a clipped cost is never predicated
    a_r6_clip_never: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && 32'(state_q.cost[lk_idx]) > 3) |-> !pred_en);

    // R6: backward branches are never predicated
    a_r6_back_never: assert property (@(posedge clk) disable iff (!rst_n)
        lk_disp[DISP_W-1] |-> !pred_en);

    // R9: table empty in the first cycle after reset
    a_r9_empty: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (state_q.valid == '0));

    // R7: a cached target requires a hit
    a_r7_tv_hit: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid |-> lk_hit);
endmodule

// File: tb/hint_branch_predictor_tb_top.sv
module hint_branch_predictor_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_pc = '0;
    logic [15:0] lk_disp = '0;
    logic        res_valid = 1'b0;
    logic [31:0] res_pc = '0;
    logic        res_taken = 1'b0;
    logic [31:0] res_target = '0;
    logic        res_measured = 1'b0;
    logic [7:0]  res_cycles = '0;
    logic        pred_taken, pred_en, tgt_valid;
    logic [31:0] pred_target;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hint_branch_predictor dut_i (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_disp(lk_disp),
        .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
        .res_target(res_target), .res_measured(res_measured),
        .res_cycles(res_cycles), .pred_taken(pred_taken), .pred_en(pred_en),
        .tgt_valid(tgt_valid), .pred_target(pred_target)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic look(input logic [31:0] pc, input logic [15:0] disp);
        @(negedge clk);
        lk_pc   = pc;
        lk_disp = disp;
        #1;
    endtask

    task automatic resolve(input logic [31:0] pc, input logic tk, input logic [31:0] tgt,
                           input logic meas, input logic [7:0] cyc);
        @(negedge clk);
        res_valid = 1'b1; res_pc = pc; res_taken = tk;
        res_target = tgt; res_measured = meas; res_cycles = cyc;
        @(posedge clk);
        @(negedge clk);
        res_valid = 1'b0; res_measured = 1'b0;
    endtask

    task automatic t_reset_static;
        look(32'h100, 16'h0008);
        chk("R9 R1 fwd hint0 taken", 32'(pred_taken), 0);
        chk("R2 fwd nt predicated", 32'(pred_en), 1);
        chk("R2 miss tv", 32'(tgt_valid), 0);
        chk("R7 static target", pred_target, 32'h108);
        look(32'h100, 16'h0009);
        chk("R1 fwd hint1 taken", 32'(pred_taken), 1);
        chk("R2 fwd taken no pred", 32'(pred_en), 0);
        chk("R7 target hint masked", pred_target, 32'h108);
        look(32'h100, 16'hFFF8);
        chk("R1 back hint0 taken", 32'(pred_taken), 1);
        chk("R7 back target", pred_target, 32'h0F8);
        look(32'h100, 16'hFFF9);
        chk("R1 back hint1 taken", 32'(pred_taken), 0);
        chk("R2 back nt no pred", 32'(pred_en), 0);
    endtask

    task automatic t_cost2_rate;
        resolve(32'h202, 1'b1, 32'h3000, 1'b1, 8'd2);
        look(32'h202, 16'h0008);
        chk("R3 history after alloc", 32'(pred_taken), 1);
        chk("R7 tv after taken", 32'(tgt_valid), 1);
        chk("R7 cached target", pred_target, 32'h3000);
        chk("R6 cost2 rate8 pred", 32'(pred_en), 1);
        for (int i = 0; i < 5; i++) resolve(32'h202, 1'b1, 32'h3000, 1'b0, 8'd0);
        look(32'h202, 16'h0008);
        chk("R4 R6 cost2 rate13 pred", 32'(pred_en), 1);
        resolve(32'h202, 1'b1, 32'h3000, 1'b0, 8'd0);
        look(32'h202, 16'h0008);
        chk("R4 R6 cost2 rate14 no pred", 32'(pred_en), 0);
        resolve(32'h202, 1'b1, 32'h3000, 1'b0, 8'd0);
        resolve(32'h202, 1'b1, 32'h3000, 1'b0, 8'd0);
        resolve(32'h202, 1'b0, 32'h7777, 1'b0, 8'd0);
        look(32'h202, 16'h0008);
        chk("R4 saturated then 14", 32'(pred_en), 0);
        chk("R3 history not taken", 32'(pred_taken), 0);
        chk("R7 nt keeps target", pred_target, 32'h3000);
        resolve(32'h202, 1'b0, 32'h7777, 1'b0, 8'd0);
        look(32'h202, 16'h0008);
        chk("R4 down to 13", 32'(pred_en), 1);
    endtask

    task automatic t_cost3;
        resolve(32'h404, 1'b0, 32'h9999, 1'b1, 8'd3);
        look(32'h404, 16'h0008);
        chk("R6 cost3 rate7 pred", 32'(pred_en), 1);
        chk("R7 nt alloc no tv", 32'(tgt_valid), 0);
        chk("R7 nt alloc target", pred_target, 32'h40C);
        for (int i = 0; i < 3; i++) resolve(32'h404, 1'b1, 32'h4400, 1'b0, 8'd0);
        look(32'h404, 16'h0008);
        chk("R6 cost3 rate10 pred", 32'(pred_en), 1);
        resolve(32'h404, 1'b1, 32'h4400, 1'b0, 8'd0);
        look(32'h404, 16'h0008);
        chk("R6 cost3 rate11 no pred", 32'(pred_en), 0);
        chk("R7 target after taken", pred_target, 32'h4400);
    endtask

    task automatic t_clip;
        resolve(32'h606, 1'b0, 32'h0, 1'b1, 8'd200);
        look(32'h606, 16'h0008);
        chk("R5 R6 clipped never", 32'(pred_en), 0);
        resolve(32'h808, 1'b1, 32'h8800, 1'b1, 8'd1);
        for (int i = 0; i < 8; i++) resolve(32'h808, 1'b1, 32'h8800, 1'b0, 8'd0);
        look(32'h808, 16'h0008);
        chk("R6 cost1 rate15 pred", 32'(pred_en), 1);
        resolve(32'hA0A, 1'b0, 32'h0, 1'b0, 8'd0);
        look(32'hA0A, 16'h0008);
        chk("R5 unmeasured cost0 pred", 32'(pred_en), 1);
        resolve(32'hA0A, 1'b0, 32'h0, 1'b1, 8'd5);
        look(32'hA0A, 16'h0008);
        chk("R5 measured 5 no pred", 32'(pred_en), 0);
        resolve(32'hA0A, 1'b0, 32'h0, 1'b0, 8'd0);
        look(32'hA0A, 16'h0008);
        chk("R5 unmeasured keeps cost", 32'(pred_en), 0);
    endtask

    task automatic t_replace;
        resolve(32'h1202, 1'b0, 32'h0, 1'b0, 8'd0);
        look(32'h1202, 16'h0009);
        chk("R3 new tag hit history", 32'(pred_taken), 0);
        look(32'h202, 16'h0008);
        chk("R3 evicted miss tv", 32'(tgt_valid), 0);
        chk("R3 evicted miss target", pred_target, 32'h20A);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        lk_pc = 32'hC0C; lk_disp = 16'h0008;
        res_valid = 1'b1; res_pc = 32'hC0C; res_taken = 1'b1;
        res_target = 32'h5000; res_measured = 1'b0; res_cycles = 8'd0;
        #1;
        chk("R8 same cycle old tv", 32'(tgt_valid), 0);
        chk("R8 same cycle old target", pred_target, 32'hC14);
        @(posedge clk);
        @(negedge clk);
        res_valid = 1'b0;
        #1;
        chk("R8 next cycle tv", 32'(tgt_valid), 1);
        chk("R8 next cycle target", pred_target, 32'h5000);
        look(32'hC0C, 16'hFFF8);
        chk("R6 backward hit no pred", 32'(pred_en), 0);
        chk("R3 backward hit history", 32'(pred_taken), 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset_static();
        t_cost2_rate();
        t_cost3();
        t_clip();
        t_replace();
        t_same_cycle();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule